// File: doc/BRIEF.md
# Processor Interrupt Level Arbiter

This block decides which interrupt a processor core should take next. It combines external level request lines with the software-interrupt register into one 16-bit pending vector. Either of the two timer-match bits in that register turns on level 14. The block then compares the vector with the core's current priority level and picks the highest pending level above it. It posts a registered hard-interrupt request that carries a trap-type code.

It also contains a one-entry vector-interrupt receiver. While that receiver is occupied it outranks every level interrupt, and level arbitration stops completely. A raise fills the receiver and loads its data words. A lower empties it and withdraws the request.

Outputs update once per clock, on the edge after the inputs change. The request and the trap type are both registered.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, irq_req is 0, irq_tt is 0, vec_busy is 0 and all three vector data words are 0.
- R2: The pending vector is lvl_req ORed with soft_int[15:0], with soft_int[0] (tick match) masked out. If soft_int[0] or soft_int[16] (system-tick match) is set, pending bit 14 is forced to 1.
- R3: When the receiver is idle and the pending vector, read as an unsigned number, is below (2 << cur_pil), the next cycle has irq_req = 0 and irq_tt = 0. With cur_pil = 15 this is always the case.
- R4: When enabled and eligible, the highest set pending bit above cur_pil is chosen, and irq_tt becomes 0x40 | level.
- R5: When int_en is 0 and the receiver is idle, the next cycle has irq_req = 0 and irq_tt = 0.
- R6: If trap_lvl > 0, trap_type[8:4] equals 0x4 and trap_type is greater than the new level code, the new code is not posted and irq_req and irq_tt keep their values.
- R7: A level request is written only when its trap type differs from the registered irq_tt. Otherwise the outputs hold.
- R8: A vec_raise while idle sets vec_busy, sets irq_tt to 0x60, sets irq_req to 1, loads vec_data0 with (0x1F << 6) | vec_idx, and clears vec_data1 and vec_data2.
- R9: While vec_busy is 1, level inputs have no effect. After the receiver empties, arbitration resumes on the next cycle.
- R10: A vec_lower while busy clears vec_busy and irq_req and leaves irq_tt unchanged. A vec_raise while busy is ignored. A raise while idle takes precedence over a lower in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_req | input | 16 | External interrupt level lines |
| soft_int | input | 17 | Software interrupt register (bit 0 tick match, bit 16 system-tick match) |
| cur_pil | input | 4 | Current processor interrupt level |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | TL_W | Current trap level |
| trap_type | input | 9 | Trap type being serviced |
| vec_raise | input | 1 | Vector interrupt raise |
| vec_lower | input | 1 | Vector interrupt lower |
| vec_idx | input | IDX_W | Vector interrupt index |
| irq_req | output | 1 | Hard interrupt request |
| irq_tt | output | 9 | Selected trap type |
| vec_busy | output | 1 | Vector receiver occupied |
| vec_data0 | output | DATA_W | Vector data word 0 |
| vec_data1 | output | DATA_W | Vector data word 1 |
| vec_data2 | output | DATA_W | Vector data word 2 |

## Verification
The bench uses the defaults IDX_W = 6, TL_W = 3 and DATA_W = 64. With these, the all-ones index 63 drives vec_data0 to 0x7FF, so every index bit sits directly beside the fixed 0x1F field where a misplaced bit would show. A 3-bit trap level lets the bench contrast nonzero and zero levels in the nesting check. The four-bit priority field reaches 15, the setting that shuts out every level.

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
  parameter int IDX_W  = 6,
  parameter int TL_W   = 3,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       lvl_req,
  input  logic [16:0]       soft_int,
  input  logic [3:0]        cur_pil,
  input  logic              int_en,
  input  logic [TL_W-1:0]   trap_lvl,
  input  logic [8:0]        trap_type,
  input  logic              vec_raise,
  input  logic              vec_lower,
  input  logic [IDX_W-1:0]  vec_idx,
  output logic              irq_req,
  output logic [8:0]        irq_tt,
  output logic              vec_busy,
  output logic [DATA_W-1:0] vec_data0,
  output logic [DATA_W-1:0] vec_data1,
  output logic [DATA_W-1:0] vec_data2
);
  localparam logic [8:0] EXT_BASE = 9'h040;
  localparam logic [8:0] VEC_TT   = 9'h060;

  logic [15:0] pend;
  logic        timer_hit;
  assign timer_hit = soft_int[0] | soft_int[16];
  assign pend = lvl_req | (soft_int[15:0] & 16'hFFFE) | (timer_hit ? 16'h4000 : 16'h0000);

  logic eligible;
  assign eligible = {1'b0, pend} >= (17'd2 << cur_pil);

  logic [3:0] win_lvl;
  always_comb begin
    win_lvl = 4'd0;
    for (int i = 1; i < 16; i++)
      if (pend[i] && (4'(i) > cur_pil)) win_lvl = 4'(i);
  end

  logic [8:0] new_tt;
  logic       nested_block;
  assign new_tt = EXT_BASE | {5'd0, win_lvl};
  assign nested_block = (trap_lvl != '0) && (trap_type > new_tt) &&
                        ((trap_type & 9'h1F0) == EXT_BASE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_req   <= 1'b0;
      irq_tt    <= '0;
      vec_busy  <= 1'b0;
      vec_data0 <= '0;
      vec_data1 <= '0;
      vec_data2 <= '0;
    end else if (vec_raise && !vec_busy) begin
      vec_busy  <= 1'b1;
      irq_tt    <= VEC_TT;
      irq_req   <= 1'b1;
      vec_data0 <= DATA_W'({5'h1F, 6'd0}) | DATA_W'(vec_idx);
      vec_data1 <= '0;
      vec_data2 <= '0;
    end else if (vec_lower && vec_busy) begin
      vec_busy <= 1'b0;
      irq_req  <= 1'b0;
    end else if (!vec_busy) begin
      if (!eligible || !int_en) begin
        irq_req <= 1'b0;
        irq_tt  <= '0;
      end else if (!nested_block && irq_tt != new_tt) begin
        irq_tt  <= new_tt;
        irq_req <= 1'b1;
      end
    end
  end
endmodule

module irq_level_arbiter_chk #(
  parameter int IDX_W  = 6,
  parameter int TL_W   = 3,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       lvl_req,
  input logic [16:0]       soft_int,
  input logic [3:0]        cur_pil,
  input logic              int_en,
  input logic [TL_W-1:0]   trap_lvl,
  input logic [8:0]        trap_type,
  input logic              vec_raise,
  input logic              vec_lower,
  input logic [IDX_W-1:0]  vec_idx,
  input logic              irq_req,
  input logic [8:0]        irq_tt,
  input logic              vec_busy,
  input logic [DATA_W-1:0] vec_data0,
  input logic [DATA_W-1:0] vec_data1,
  input logic [DATA_W-1:0] vec_data2
);
  assert_vec_owns_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_busy |-> (irq_req && irq_tt == 9'h060));

  assert_raise_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_raise && !vec_busy) |=> (vec_busy && vec_data1 == '0 && vec_data2 == '0 &&
      vec_data0 == (DATA_W'(11'h7C0) | DATA_W'($past(vec_idx)))));

  assert_raise_busy_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_busy && vec_raise && !vec_lower) |=> (vec_busy && $stable(vec_data0)));

  assert_disable_withdraw_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_en && !vec_busy && !vec_raise) |=> (!irq_req && irq_tt == '0));

  assert_top_pil_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_pil == 4'hF && !vec_busy && !vec_raise) |=> !irq_req);

  assert_level_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !vec_busy) |-> (irq_tt[8:4] == 5'h04));
endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(.IDX_W(IDX_W), .TL_W(TL_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_irq_level_arbiter.sv
module sim_irq_level_arbiter;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [15:0] lvl_req;
  logic [16:0] soft_int;
  logic [3:0]  cur_pil;
  logic        int_en;
  logic [2:0]  trap_lvl;
  logic [8:0]  trap_type;
  logic        vec_raise, vec_lower;
  logic [5:0]  vec_idx;
  logic        irq_req, vec_busy;
  logic [8:0]  irq_tt;
  logic [63:0] vec_data0, vec_data1, vec_data2;

  irq_level_arbiter #(.IDX_W(6), .TL_W(3), .DATA_W(64)) u0 (.*);

  int checks = 0, failures = 0;
  bit done = 0;

  logic        q_req[$];
  logic [8:0]  q_tt[$];
  logic        q_busy[$];
  logic [63:0] q_d0[$];
  string       q_tag[$];

  logic        m_req, m_busy;
  logic [8:0]  m_tt;
  logic [63:0] m_d0;

  task automatic check(string tag, logic r, logic [8:0] t, logic b, logic [63:0] d);
    checks++;
    if (irq_req !== r || irq_tt !== t || vec_busy !== b || vec_data0 !== d ||
        vec_data1 !== 64'd0 || vec_data2 !== 64'd0) begin
      failures++;
      $display("FAIL %s: got req=%0b tt=%h busy=%0b d0=%h d1=%h d2=%h exp req=%0b tt=%h busy=%0b d0=%h d1=0 d2=0",
               tag, irq_req, irq_tt, vec_busy, vec_data0, vec_data1, vec_data2, r, t, b, d);
    end
  endtask

  task automatic step(string tag, logic [15:0] l, logic [16:0] s, logic [3:0] p, logic e,
                      logic [2:0] tl, logic [8:0] tt, logic ra, logic lo, logic [5:0] ix);
    logic [15:0] pend;
    logic [8:0]  nt;
    @(negedge clk);
    lvl_req = l; soft_int = s; cur_pil = p; int_en = e;
    trap_lvl = tl; trap_type = tt; vec_raise = ra; vec_lower = lo; vec_idx = ix;
    pend = l | (s[15:0] & 16'hFFFE);
    if (s[0] || s[16]) pend[14] = 1'b1;
    if (ra && !m_busy) begin
      m_busy = 1; m_req = 1; m_tt = 9'h060; m_d0 = 64'h7C0 | 64'(ix);
    end else if (lo && m_busy) begin
      m_busy = 0; m_req = 0;
    end else if (!m_busy) begin
      if ({1'b0, pend} < (17'd2 << p) || !e) begin
        m_req = 0; m_tt = 0;
      end else begin
        nt = 0;
        for (int i = 15; i > int'(p); i--) if (pend[i] && nt == 0) nt = 9'h040 | 9'(i);
        if (!(tl != 0 && tt > nt && (tt & 9'h1F0) == 9'h040) && m_tt != nt) begin
          m_tt = nt; m_req = 1;
        end
      end
    end
    q_req.push_back(m_req); q_tt.push_back(m_tt); q_busy.push_back(m_busy);
    q_d0.push_back(m_d0); q_tag.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (q_tag.size() > 0)
      check(q_tag.pop_front(), q_req.pop_front(), q_tt.pop_front(), q_busy.pop_front(), q_d0.pop_front());
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; lvl_req = 0; soft_int = 0; cur_pil = 0; int_en = 1;
    trap_lvl = 0; trap_type = 0; vec_raise = 0; vec_lower = 0; vec_idx = 0;
    m_req = 0; m_busy = 0; m_tt = 0; m_d0 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 check("R1", 0, 9'h0, 0, 64'h0);
    step("R4", 16'h0020, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R4", 16'h0420, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R7", 16'h0420, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R2", 16'h0000, 17'h00001, 0, 1, 0, 0, 0, 0, 0);
    step("R2", 16'h0000, 17'h10000, 0, 1, 0, 0, 0, 0, 0);
    step("R2", 16'h0000, 17'h00008, 0, 1, 0, 0, 0, 0, 0);
    step("R2", 16'h0000, 17'h00000, 0, 1, 0, 0, 0, 0, 0);
    step("R3", 16'h0000, 17'h00008, 3, 1, 0, 0, 0, 0, 0);
    step("R3", 16'h0010, 17'h00000, 3, 1, 0, 0, 0, 0, 0);
    step("R3", 16'hFFFF, 17'h1FFFF, 15, 1, 0, 0, 0, 0, 0);
    step("R4", 16'h0020, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R5", 16'h0020, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R6", 16'h0020, 0, 0, 1, 1, 9'h04C, 0, 0, 0);
    step("R6", 16'h0020, 0, 0, 1, 1, 9'h044, 0, 0, 0);
    step("R6", 16'h0040, 0, 0, 1, 0, 9'h04C, 0, 0, 0);
    step("R6", 16'h0080, 0, 0, 1, 2, 9'h07C, 0, 0, 0);
    step("R8", 16'h0080, 0, 0, 1, 0, 0, 1, 0, 6'd63);
    step("R9", 16'h8000, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R10", 16'h8000, 0, 0, 1, 0, 0, 1, 0, 6'd5);
    step("R10", 16'h8000, 0, 0, 1, 0, 0, 0, 1, 0);
    step("R9", 16'h8000, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R10", 16'h0000, 0, 0, 1, 0, 0, 1, 1, 6'd9);
    step("R10", 16'h0000, 0, 0, 1, 0, 0, 0, 1, 0);
    step("R3", 16'h0000, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R8", 16'h0001, 0, 0, 1, 0, 0, 1, 0, 6'd0);
    step("R10", 16'h0000, 0, 0, 1, 0, 0, 0, 1, 0);
    step("R1", 16'h0000, 0, 0, 1, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule